// File: doc/BRIEF.md
# Periodic Tick Generator with Watchdog

This block runs one free-running binary chain off the main clock. It has a divide-by-two stage in front of a 21-bit counter. A wrap of the low bits up to a chosen bit position is a tap, and each tap fires at a fixed power-of-two period. A two-bit selector picks one of four taps to set a sticky interval flag. The interrupt output is that flag gated by an enable bit. Software clears the flag with a one-cycle strobe.

The same chain also drives a watchdog. A further tap, with a period of 2^21 cycles by default, advances a small counter. The watchdog stays idle until software enables it, and from then on it cannot be switched off short of a system reset. Each clear strobe restarts the small counter but leaves the chain alone. If no clear arrives for long enough, the block raises a reset request and holds it until reset. The chain phase at the clear is unknown, so the timeout falls anywhere between one and two watchdog tap periods.

The asynchronous active-low reset is released through a two-stage synchroniser.

Top module: `tbt_timebase`

## Requirements
- R1: While reset is held and right after it, `ivl_irq` and `wd_reset_req` are 0.
- R2: With `ivl_sel` at 0, 1, 2 or 3 the interval flag sets every 2^(TAP0+2), 2^(TAP1+2), 2^(TAP2+2) or 2^(CHAIN_W+1) clock cycles. With the defaults these are 2^13, 2^15, 2^18 and 2^22 cycles.
- R3: Once set, the interval flag stays set until `ivl_clr` is applied, whatever the number of further tap events.
- R4: An `ivl_clr` pulse clears the flag on the next edge. If a tap event lands on the same edge as the clear, the set takes priority and the flag stays 1.
- R5: The flag sets whether or not interrupts are enabled. `ivl_irq` shows the flag only while `ivl_irq_en` is 1.
- R6: While the watchdog has never been enabled, `wd_reset_req` stays 0 however long `wd_clr` is absent.
- R7: After a cycle with `wd_en` at 1, the watchdog stays armed even if `wd_en` later returns to 0.
- R8: With the watchdog armed, `wd_reset_req` rises N cycles after the edge of the last `wd_clr`, where P < N <= 2P and P = 2^(WDT_TAP+2). With the defaults P is 2^21.
- R9: Clearing the armed watchdog at intervals of at most P cycles keeps `wd_reset_req` at 0.
- R10: `wd_clr` does not disturb the chain, so interval periods stay the same even with `wd_clr` held at 1.
- R11: Once raised, `wd_reset_req` stays at 1 until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ivl_sel | input | 2 | Interval tap select, 0 = shortest, 3 = longest |
| ivl_irq_en | input | 1 | Interval interrupt enable |
| ivl_clr | input | 1 | One-cycle strobe that clears the interval flag |
| wd_en | input | 1 | Arms the watchdog (sticky) |
| wd_clr | input | 1 | Restarts the watchdog count |
| ivl_irq | output | 1 | Interval interrupt, flag AND enable |
| wd_reset_req | output | 1 | Watchdog reset request, held until reset |

## Verification
The assertions assume that `ivl_sel`, the strobes and the enables are synchronous to `clk` and settled before each rising edge. They also assume that the synchronised reset is the only thing that returns the watchdog to idle. The bench changes inputs only at falling edges and measures every period between two observed flag events, never from reset. This keeps the checks independent of synchroniser latency. The bench uses a shortened chain, so the longest interval and the full watchdog window both fit in the run.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  localparam int NUM_IVL  = 4;
  localparam int SEL_W    = $clog2(NUM_IVL);
  localparam int WD_CNT_W = 2;
  // Watchdog ticks counted since last clear at which reset is requested
  localparam logic [WD_CNT_W-1:0] WD_TERM = 2'd2;

  typedef logic [SEL_W-1:0]    ivl_sel_t;
  typedef logic [WD_CNT_W-1:0] wd_cnt_t;
endpackage

// File: rtl/tbt_chain.sv
module tbt_chain #(
  parameter int CHAIN_W = 21,
  parameter int NT      = 5,
  parameter logic [NT*8-1:0] TAPS = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [NT-1:0] tap_wrap
);
  logic               pre_q, pre_d;
  logic [CHAIN_W-1:0] cnt_q, cnt_d;
  logic [CHAIN_W-1:0] ones;

  always_comb begin
    pre_d = ~pre_q;
    cnt_d = cnt_q;
    if (pre_q) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  // prefix AND: ones[k] means bits k..0 are all one
  assign ones[0] = cnt_q[0];
  for (genvar gk = 1; gk < CHAIN_W; gk++) begin : g_prefix
    assign ones[gk] = ones[gk-1] & cnt_q[gk];
  end

  for (genvar gt = 0; gt < NT; gt++) begin : g_tap
    localparam int IDX = int'(TAPS[gt*8 +: 8]);
    assign tap_wrap[gt] = pre_q & ones[IDX];
  end

  // R10: counter advances exactly on prescaler phase
  a_r10_chain_step: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r10_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_q |=> $stable(cnt_q));
endmodule

// File: rtl/tbt_ivl.sv
module tbt_ivl
  import tbt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IVL-1:0] tap_ev,
  input  ivl_sel_t           sel,
  input  logic               irq_en,
  input  logic               clr,
  output logic               irq
);
  logic flag_q, flag_d, set_ev;

  always_comb begin
    set_ev = tap_ev[sel];
    flag_d = set_ev | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign irq = flag_q & irq_en;

  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  a_r4_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_ev) |=> !flag_q);
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag_q);
endmodule

// File: rtl/tbt_wdt.sv
module tbt_wdt
  import tbt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic clr,
  output logic req
);
  logic    arm_q, arm_d;
  logic    req_q, req_d;
  wd_cnt_t cnt_q, cnt_d;

  always_comb begin
    arm_d = arm_q | en;
    cnt_d = cnt_q;
    if (!arm_q || clr)                 cnt_d = '0;
    else if (tick && cnt_q != WD_TERM) cnt_d = cnt_q + 1'b1;
    req_d = req_q | (cnt_d == WD_TERM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      arm_q <= arm_d;
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req = req_q;

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> req_q);
  a_r7_arm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |=> arm_q);
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_q |-> !req_q);
  a_r8_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= WD_TERM);
endmodule

// File: rtl/tbt_timebase.sv
module tbt_timebase
  import tbt_pkg::*;
#(
  parameter int CHAIN_W = 21,
  parameter int TAP0    = 11,
  parameter int TAP1    = 13,
  parameter int TAP2    = 16,
  parameter int WDT_TAP = 19
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ivl_sel,
  input  logic       ivl_irq_en,
  input  logic       ivl_clr,
  input  logic       wd_en,
  input  logic       wd_clr,
  output logic       ivl_irq,
  output logic       wd_reset_req
);
  localparam int TAP3 = CHAIN_W - 1;
  localparam int NT   = NUM_IVL + 1;
  localparam logic [NT*8-1:0] TAPS =
    {8'(WDT_TAP), 8'(TAP3), 8'(TAP2), 8'(TAP1), 8'(TAP0)};

  logic [1:0]    rst_sync_q;
  logic          rst_core_n;
  logic [NT-1:0] wraps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  tbt_chain #(.CHAIN_W(CHAIN_W), .NT(NT), .TAPS(TAPS)) u_chain (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .tap_wrap (wraps)
  );

  tbt_ivl u_ivl (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .tap_ev (wraps[NUM_IVL-1:0]),
    .sel    (ivl_sel),
    .irq_en (ivl_irq_en),
    .clr    (ivl_clr),
    .irq    (ivl_irq)
  );

  tbt_wdt u_wdt (
    .clk   (clk),
    .rst_n (rst_core_n),
    .tick  (wraps[NUM_IVL]),
    .en    (wd_en),
    .clr   (wd_clr),
    .req   (wd_reset_req)
  );

  // R5: interrupt never shows while masked
  a_r5_mask: assert property (@(posedge clk) disable iff (!rst_core_n)
    !ivl_irq_en |-> !ivl_irq);
endmodule

// File: tb/tbt_timebase_tb.sv
module tbt_timebase_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW   = 10;
  localparam int WT   = 7;
  localparam int WD_P = 1 << (WT + 2);   // 512
  // {sel, expected period}: taps 1,3,5,9
  localparam int VEC [4][2] = '{'{0, 8}, '{1, 32}, '{2, 128}, '{3, 2048}};

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] ivl_sel;
  logic ivl_irq_en, ivl_clr, wd_en, wd_clr;
  logic ivl_irq, wd_reset_req;
  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbt_timebase #(.CHAIN_W(CW), .TAP0(1), .TAP1(3), .TAP2(5), .WDT_TAP(WT)) dut_i (
    .clk(clk), .rst_n(rst_n), .ivl_sel(ivl_sel), .ivl_irq_en(ivl_irq_en),
    .ivl_clr(ivl_clr), .wd_en(wd_en), .wd_clr(wd_clr),
    .ivl_irq(ivl_irq), .wd_reset_req(wd_reset_req));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_irq();
    for (int g = 0; g < 5000 && !ivl_irq; g++) @(negedge clk);
  endtask

  // cycles between two consecutive flag sets
  task automatic measure(output int n);
    wait_irq();
    ivl_clr = 1'b1; @(negedge clk); ivl_clr = 1'b0; n = 1;
    while (!ivl_irq && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(ivl_irq == 1'b0 && wd_reset_req == 1'b0, "R1", {ivl_irq, wd_reset_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(wd_reset_req == 1'b0, "R1", wd_reset_req, 0);
  endtask

  // cycles from a clear edge to the reset request
  task automatic wd_timeout(output int n);
    wd_clr = 1'b1; @(negedge clk); wd_clr = 1'b0; n = 1;
    while (!wd_reset_req && n < 3 * WD_P) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: run hung actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    ivl_sel = 2'd0; ivl_irq_en = 1'b1; ivl_clr = 1'b0; wd_en = 1'b0; wd_clr = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R2 table walk
    for (int v = 0; v < 4; v++) begin
      ivl_sel = VEC[v][0][1:0];
      ivl_clr = 1'b1; @(negedge clk); ivl_clr = 1'b0;
      measure(n);
      check(n == VEC[v][1], "R2 period", n, VEC[v][1]);
    end
    // just past a sel=3 event: clear must drop the flag (R4)
    ivl_clr = 1'b1; @(negedge clk); ivl_clr = 1'b0;
    check(ivl_irq == 1'b0, "R4 clear", ivl_irq, 0);

    // R5: flag sets while masked, shows on enable
    ivl_sel = 2'd0; ivl_irq_en = 1'b0;
    repeat (20) @(negedge clk);
    check(ivl_irq == 1'b0, "R5 masked", ivl_irq, 0);
    ivl_irq_en = 1'b1; #1;
    check(ivl_irq == 1'b1, "R5 unmask", ivl_irq, 1);
    // R3: sticky through many events
    repeat (40) @(negedge clk);
    check(ivl_irq == 1'b1, "R3 sticky", ivl_irq, 1);

    // R4: set beats a coincident clear (sel=1, period 32)
    ivl_sel = 2'd1;
    ivl_clr = 1'b1; @(negedge clk); ivl_clr = 1'b0;
    wait_irq();
    ivl_clr = 1'b1; @(negedge clk); ivl_clr = 1'b0;
    check(ivl_irq == 1'b0, "R4 clear", ivl_irq, 0);
    repeat (30) @(negedge clk);
    ivl_clr = 1'b1; @(negedge clk); ivl_clr = 1'b0;
    check(ivl_irq == 1'b1, "R4 set wins", ivl_irq, 1);
    @(negedge clk);
    check(ivl_irq == 1'b1, "R4 set wins hold", ivl_irq, 1);

    // R6: idle watchdog never bites
    repeat (3 * WD_P) @(negedge clk);
    check(wd_reset_req == 1'b0, "R6 idle", wd_reset_req, 0);

    // arm, then R9: periodic clears keep it quiet
    wd_en = 1'b1; @(negedge clk); wd_en = 1'b0;
    for (int k = 0; k < 8; k++) begin
      wd_clr = 1'b1; @(negedge clk); wd_clr = 1'b0;
      repeat (WD_P / 2 - 1) @(negedge clk);
    end
    check(wd_reset_req == 1'b0, "R9 serviced", wd_reset_req, 0);

    // R8 window, first phase
    wd_timeout(n);
    check(n > WD_P && n <= 2 * WD_P, "R8 window", n, WD_P);
    // R11 hold, even with clears
    wd_clr = 1'b1; repeat (50) @(negedge clk); wd_clr = 1'b0;
    check(wd_reset_req == 1'b1, "R11 hold", wd_reset_req, 1);
    do_reset();
    check(wd_reset_req == 1'b0, "R11 reset clears", wd_reset_req, 0);

    // R7: arm then drop enable; R10: clears held, chain unaffected
    wd_en = 1'b1; @(negedge clk); wd_en = 1'b0;
    wd_clr = 1'b1;
    ivl_sel = 2'd1;
    ivl_clr = 1'b1; @(negedge clk); ivl_clr = 1'b0;
    measure(n);
    check(n == 32, "R10 period with wd_clr", n, 32);
    repeat (137) @(negedge clk);
    wd_clr = 1'b0;
    wd_timeout(n);
    check(wd_reset_req == 1'b1, "R7 stays armed", wd_reset_req, 1);
    check(n > WD_P && n <= 2 * WD_P, "R8 window phase2", n, WD_P);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule